// File: doc/BRIEF.md
# Width-Matching Video Serializer

This block sits between a 32-bit line-buffer read port and a print engine's video input. It pulls whole words from the buffer through a valid/pop handshake and hands them out one pixel per video strobe: a full byte per strobe for colour or grey-scale engines, or a single bit per strobe for bi-level engines. Byte order within a word and bit order within a byte are each selected by a mode input. Reversing both is how the second side of a duplex page is printed.

A margin-select input, driven by external margin counters, replaces buffer data with a margin colour byte. In bi-level mode the bits of that byte are sent out serially instead. A saturation option for bi-level mode copies the serial bit onto all eight byte lines, so a byte-wide engine can print bi-level data. The first word is fetched ahead of time, so the first strobe after reset already has data. Running out of words costs nothing but a cleared line-valid flag.

Top module: `vid_serializer`

## Requirements
- R1: In colour mode (mode_bilevel=0) each buffer strobe outputs one byte. With order_little=0 the bytes of a word come out as bits [31:24], [23:16], [15:8], [7:0]. With order_little=1 the order is reversed, starting at [7:0].
- R2: In bi-level mode (mode_bilevel=1) each buffer strobe outputs one bit on ser_out, 32 bits per word. Bytes follow the R1 order. Within a byte, bit_msb_first=0 sends bit 0 first and bit_msb_first=1 sends bit 7 first.
- R3: bit_msb_first has no effect on the byte output in colour mode.
- R4: ser_out is low whenever the mode in the cycle of the strobe was colour.
- R5: In bi-level mode with sat_replicate=1, pix_out equals ser_out copied to all eight lines. With sat_replicate=0, pix_out shows margin_color. In colour mode sat_replicate has no effect.
- R6: Output data and line_valid appear on the clock edge after strobe_n is sampled low. A cycle without a strobe gives line_valid=0 and zero data.
- R7: With out_en_n high at the strobe, pix_out and ser_out are zero on the following cycle. The read still takes place and line_valid still reports it.
- R8: With margin_sel high, a strobe outputs margin_color in colour mode. In bi-level mode it outputs the next bit of margin_color in the R2 bit order, using a separate 3-bit margin position. The buffer read position does not move.
- R9: A new word is popped once 4 bytes or 32 bits of the held word have been used, in the same cycle as the last read if a word is offered. A word is fetched ahead whenever nothing is held. word_pop is only high while word_valid is high.
- R10: A buffer strobe while no word is held gives line_valid=0 and zero data, and consumes nothing.
- R11: Reset (rst_n low) clears the outputs and the read position, and drops the held word. The first read after reset comes from the next word popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low video-side reset, asynchronous |
| mode_bilevel | input | 1 | 0 = byte per strobe, 1 = bit per strobe |
| order_little | input | 1 | Byte order within a word |
| bit_msb_first | input | 1 | Bit order within a byte (bi-level only) |
| sat_replicate | input | 1 | Copy serial bit onto byte bus (bi-level only) |
| margin_color | input | 8 | Margin colour byte |
| margin_sel | input | 1 | Output margin instead of buffer data |
| word_valid | input | 1 | Buffer offers a word |
| word_data | input | 32 | Offered word |
| word_pop | output | 1 | Word accepted this cycle |
| strobe_n | input | 1 | Active-low read strobe |
| out_en_n | input | 1 | Active-low data output enable |
| pix_out | output | 8 | Byte-wide video output |
| ser_out | output | 1 | Serial video output |
| line_valid | output | 1 | Output of the previous strobe is valid |

## Verification
Several pairs of functions can land in the same cycle. Two matter most. The first is the last read of a word together with the pop of the next word: back-to-back bytes across a word boundary show the following word's first byte with no gap. If no next word is offered, a read in the following cycle must report underflow. The second is a margin strobe in the middle of a word. The bench places one between buffer reads and expects the buffer sequence to pick up exactly where it stopped. It also checks that a disabled output blanks the data while line_valid still counts the consumed byte.

// File: rtl/vser_pkg.sv
package vser_pkg;
   // Lane position of a sub-word given the read order.
   function automatic int unsigned lane_of(input int unsigned pos,
                                           input int unsigned lanes,
                                           input bit little);
      return little ? pos : (lanes - 1 - pos);
   endfunction

   // Bit position inside a pixel given the shift direction.
   function automatic int unsigned bit_of(input int unsigned j,
                                          input int unsigned pix_w,
                                          input bit msb_first);
      return msb_first ? (pix_w - 1 - j) : j;
   endfunction
endpackage

// File: rtl/vser_hold.sv
module vser_hold #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_data,
   input  logic              consume_last,
   output logic              word_pop,
   output logic              hold_vld,
   output logic [WORD_W-1:0] hold_word
);
   logic              run_q;
   logic              vld_q;
   logic [WORD_W-1:0] word_q;

   // pop while empty (prefetch) or together with the final read of a word
   assign word_pop  = run_q & word_valid & (~vld_q | consume_last);
   assign hold_vld  = vld_q;
   assign hold_word = word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         vld_q  <= 1'b0;
         word_q <= '0;
      end else begin
         run_q <= 1'b1;
         if (word_pop) begin
            vld_q  <= 1'b1;
            word_q <= word_data;
         end else if (consume_last) begin
            vld_q  <= 1'b0;
         end
      end
   end

   // R9: a pop is only taken from an offered word
   a_r9_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      word_pop |-> word_valid);

   // R10: a word finished without a replacement leaves the holder empty
   a_r10_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (consume_last && !word_valid) |=> !hold_vld);
endmodule

// File: rtl/vser_pos.sv
module vser_pos #(
   parameter  int WORD_W    = 32,
   parameter  int PIX_W     = 8,
   localparam int LANES     = WORD_W / PIX_W,
   localparam int IDX_W     = $clog2(WORD_W),
   localparam int PIX_IDX_W = $clog2(PIX_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bilevel,
   input  logic                 advance,
   input  logic                 m_advance,
   output logic [IDX_W-1:0]     idx,
   output logic [PIX_IDX_W-1:0] midx,
   output logic                 last
);
   logic [IDX_W-1:0]     idx_q;
   logic [PIX_IDX_W-1:0] midx_q;

   assign idx  = idx_q;
   assign midx = midx_q;
   assign last = bilevel ? (idx_q == IDX_W'(WORD_W - 1))
                         : (idx_q >= IDX_W'(LANES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         midx_q <= '0;
      end else begin
         if (advance)
            idx_q <= last ? '0 : idx_q + 1'b1;
         if (m_advance)
            midx_q <= midx_q + 1'b1;
      end
   end

   // R9: the read position returns to zero when a word is finished
   a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && last) |=> (idx == '0));

   // R8: a margin read leaves the buffer position untouched
   a_r8_margin_keeps_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (m_advance && !advance) |=> $stable(idx));
endmodule

// File: rtl/vser_pick.sv
module vser_pick #(
   parameter  int WORD_W    = 32,
   parameter  int PIX_W     = 8,
   parameter  bit SAT_EN    = 1'b1,
   localparam int LANES     = WORD_W / PIX_W,
   localparam int LANE_W    = $clog2(LANES),
   localparam int IDX_W     = $clog2(WORD_W),
   localparam int PIX_IDX_W = $clog2(PIX_W)
) (
   input  logic [WORD_W-1:0]    word,
   input  logic [IDX_W-1:0]     idx,
   input  logic [PIX_IDX_W-1:0] midx,
   input  logic                 bilevel,
   input  logic                 little,
   input  logic                 msb_first,
   input  logic                 saturate,
   input  logic                 margin_sel,
   input  logic [PIX_W-1:0]     margin,
   output logic [PIX_W-1:0]     pix,
   output logic                 sbit
);
   import vser_pkg::*;

   logic [PIX_W-1:0]     lane [LANES];
   logic [LANE_W-1:0]    pos;
   logic [LANE_W-1:0]    lane_no;
   logic [PIX_IDX_W-1:0] bpos;
   logic [PIX_W-1:0]     cur;
   logic                 buf_bit;
   logic                 mrg_bit;
   logic                 ser;
   logic [PIX_W-1:0]     bl_pix;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = word[g*PIX_W +: PIX_W];
   end

   always_comb begin
      pos     = bilevel ? idx[IDX_W-1:PIX_IDX_W] : idx[LANE_W-1:0];
      lane_no = LANE_W'(lane_of(32'(pos), LANES, little));
      bpos    = bilevel ? idx[PIX_IDX_W-1:0] : '0;
      cur     = lane[lane_no];
      buf_bit = cur[PIX_IDX_W'(bit_of(32'(bpos), PIX_W, msb_first))];
      mrg_bit = margin[PIX_IDX_W'(bit_of(32'(midx), PIX_W, msb_first))];
      ser     = margin_sel ? mrg_bit : buf_bit;
   end

   if (SAT_EN) begin : g_sat
      assign bl_pix = saturate ? {PIX_W{ser}} : margin;
   end else begin : g_nosat
      logic unused_sat;
      assign unused_sat = saturate;
      assign bl_pix     = margin;
   end

   assign pix  = bilevel ? bl_pix : (margin_sel ? margin : cur);
   assign sbit = bilevel & ser;
endmodule

// File: rtl/vid_serializer.sv
module vid_serializer #(
   parameter  int WORD_W    = 32,
   parameter  int PIX_W     = 8,
   parameter  bit SAT_EN    = 1'b1,
   localparam int LANES     = WORD_W / PIX_W,
   localparam int IDX_W     = $clog2(WORD_W),
   localparam int PIX_IDX_W = $clog2(PIX_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_bilevel,
   input  logic              order_little,
   input  logic              bit_msb_first,
   input  logic              sat_replicate,
   input  logic [PIX_W-1:0]  margin_color,
   input  logic              margin_sel,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_data,
   output logic              word_pop,
   input  logic              strobe_n,
   input  logic              out_en_n,
   output logic [PIX_W-1:0]  pix_out,
   output logic              ser_out,
   output logic              line_valid
);
   if (WORD_W % PIX_W != 0) begin : g_chk_div
      $error("WORD_W must be a multiple of PIX_W");
   end
   if (LANES < 2) begin : g_chk_lanes
      $error("a word must hold at least two pixels");
   end
   if ((1 << PIX_IDX_W) != PIX_W || (1 << IDX_W) != WORD_W) begin : g_chk_pow2
      $error("WORD_W and PIX_W must be powers of two");
   end

   logic                 hold_vld;
   logic [WORD_W-1:0]    hold_word;
   logic [IDX_W-1:0]     idx;
   logic [PIX_IDX_W-1:0] midx;
   logic                 last;
   logic                 buf_rd;
   logic                 mrg_rd;
   logic                 consume_last;
   logic [PIX_W-1:0]     pix_d;
   logic                 sbit_d;
   logic [PIX_W-1:0]     pix_q;
   logic                 ser_q;
   logic                 lv_q;

   assign buf_rd       = ~strobe_n & ~margin_sel & hold_vld;
   assign mrg_rd       = ~strobe_n & margin_sel;
   assign consume_last = buf_rd & last;

   vser_hold #(.WORD_W(WORD_W)) i_hold (
      .clk          (clk),
      .rst_n        (rst_n),
      .word_valid   (word_valid),
      .word_data    (word_data),
      .consume_last (consume_last),
      .word_pop     (word_pop),
      .hold_vld     (hold_vld),
      .hold_word    (hold_word)
   );

   vser_pos #(.WORD_W(WORD_W), .PIX_W(PIX_W)) i_pos (
      .clk       (clk),
      .rst_n     (rst_n),
      .bilevel   (mode_bilevel),
      .advance   (buf_rd),
      .m_advance (mrg_rd & mode_bilevel),
      .idx       (idx),
      .midx      (midx),
      .last      (last)
   );

   vser_pick #(.WORD_W(WORD_W), .PIX_W(PIX_W), .SAT_EN(SAT_EN)) i_pick (
      .word       (hold_word),
      .idx        (idx),
      .midx       (midx),
      .bilevel    (mode_bilevel),
      .little     (order_little),
      .msb_first  (bit_msb_first),
      .saturate   (sat_replicate),
      .margin_sel (margin_sel),
      .margin     (margin_color),
      .pix        (pix_d),
      .sbit       (sbit_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q <= '0;
         ser_q <= 1'b0;
         lv_q  <= 1'b0;
      end else begin
         lv_q <= buf_rd | mrg_rd;
         if ((buf_rd | mrg_rd) && !out_en_n) begin
            pix_q <= pix_d;
            ser_q <= sbit_d;
         end else begin
            pix_q <= '0;
            ser_q <= 1'b0;
         end
      end
   end

   assign pix_out    = pix_q;
   assign ser_out    = ser_q;
   assign line_valid = lv_q;

   // R6: valid output only follows a sampled strobe
   a_r6_valid_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid |-> $past(!strobe_n));

   // R4: the serial line stays low after a colour-mode cycle
   a_r4_serial_low_colour: assert property (@(posedge clk) disable iff (!rst_n)
      ser_out |-> $past(mode_bilevel));

   // R7: a disabled output enable blanks both data outputs
   a_r7_oe_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      $past(out_en_n) |-> (pix_out == '0 && !ser_out));

   // R5: saturation copies the serial bit onto every byte line
   a_r5_sat_copies: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode_bilevel && sat_replicate) |-> (pix_out == {PIX_W{ser_out}}));

   // R10: a buffer strobe with nothing held is reported as invalid
   a_r10_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!strobe_n && !margin_sel && !hold_vld) |-> !line_valid);
endmodule

// File: tb/test_vid_serializer.sv
module test_vid_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_bilevel = 1'b0;
   logic        order_little = 1'b0;
   logic        bit_msb_first = 1'b0;
   logic        sat_replicate = 1'b0;
   logic [7:0]  margin_color = 8'h5A;
   logic        margin_sel = 1'b0;
   logic        word_valid;
   logic [31:0] word_data;
   logic        word_pop;
   logic        strobe_n = 1'b1;
   logic        out_en_n = 1'b0;
   logic [7:0]  pix_out;
   logic        ser_out;
   logic        line_valid;

   int nchk = 0;
   int nerr = 0;
   int ptr = 0;
   int avail = 0;
   logic [31:0] src [0:7];

   always #5 clk = ~clk;

   assign word_valid = (ptr < avail);
   assign word_data  = (ptr < 8) ? src[ptr[2:0]] : 32'h0;
   always @(posedge clk) if (word_pop) ptr <= ptr + 1;

   vid_serializer i_vid_serializer (
      .clk(clk), .rst_n(rst_n), .mode_bilevel(mode_bilevel),
      .order_little(order_little), .bit_msb_first(bit_msb_first),
      .sat_replicate(sat_replicate), .margin_color(margin_color),
      .margin_sel(margin_sel), .word_valid(word_valid), .word_data(word_data),
      .word_pop(word_pop), .strobe_n(strobe_n), .out_en_n(out_en_n),
      .pix_out(pix_out), .ser_out(ser_out), .line_valid(line_valid)
   );

   // row: bl le mf sat ms rd oe_n | lv byte bit
   localparam logic [16:0] VEC [0:12] = '{
      {7'b0000010, 1'b1, 8'h11, 1'b0},
      {7'b0000010, 1'b1, 8'h22, 1'b0},
      {7'b0000011, 1'b1, 8'h00, 1'b0},
      {7'b0000010, 1'b1, 8'h44, 1'b0},
      {7'b0000110, 1'b1, 8'h5A, 1'b0},
      {7'b0010010, 1'b1, 8'hA5, 1'b0},
      {7'b0000000, 1'b0, 8'h00, 1'b0},
      {7'b0000010, 1'b1, 8'hC3, 1'b0},
      {7'b0000010, 1'b1, 8'h0F, 1'b0},
      {7'b0001010, 1'b1, 8'h81, 1'b0},
      {7'b0000010, 1'b0, 8'h00, 1'b0},
      {7'b0000110, 1'b1, 8'h5A, 1'b0},
      {7'b0000111, 1'b1, 8'h00, 1'b0}
   };

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; drives, then waits one full cycle
   task automatic cyc(input logic rd, input logic ms, input logic oen);
      strobe_n   = ~rd;
      margin_sel = ms;
      out_en_n   = oen;
      @(negedge clk);
   endtask

   task automatic do_reset;
      strobe_n = 1'b1;
      rst_n    = 1'b0;
      @(negedge clk);
      chk({line_valid, pix_out, ser_out} == 10'h0, "R11 reset outputs",
          {line_valid, pix_out, ser_out}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0);
   endtask

   function automatic logic exp_bit(input logic [31:0] w, input int k,
                                    input logic le, input logic mf);
      int ln = le ? (k / 8) : (3 - k / 8);
      int j  = k % 8;
      return mf ? w[8*ln + 7 - j] : w[8*ln + j];
   endfunction

   initial begin
      #1_000_000;
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      src[0] = 32'h11223344; src[1] = 32'hA5C30F81;
      src[2] = 32'h800100C5; src[3] = 32'h3C96F00D;
      src[4] = 32'h00000002; src[5] = 32'hDEADBEEF;
      src[6] = 32'h01234567; src[7] = 32'h0;
      avail = 2;
      @(negedge clk);
      do_reset();
      chk(ptr == 1, "R9 prefetch after reset", ptr, 1);

      // table: R1 R3 R5 R6 R7 R8 R9 R10 in colour mode
      for (int r = 0; r < 13; r++) begin
         mode_bilevel  = VEC[r][16];
         order_little  = VEC[r][15];
         bit_msb_first = VEC[r][14];
         sat_replicate = VEC[r][13];
         cyc(VEC[r][11], VEC[r][12], VEC[r][10]);
         chk({line_valid, pix_out, ser_out} == VEC[r][9:0],
             $sformatf("R1 R6 table row %0d", r),
             {line_valid, pix_out, ser_out}, VEC[r][9:0]);
      end
      chk(ptr == 2, "R9 pops after table", ptr, 2);

      // R2 R5: bi-level serialization, two orderings
      mode_bilevel = 1'b1; order_little = 1'b1; bit_msb_first = 1'b0;
      sat_replicate = 1'b1; margin_color = 8'h3C; avail = 4;
      do_reset();
      for (int k = 0; k < 32; k++) begin
         logic e;
         e = exp_bit(src[2], k, 1'b1, 1'b0);
         cyc(1'b1, 1'b0, 1'b0);
         chk({line_valid, ser_out, pix_out} == {1'b1, e, {8{e}}},
             $sformatf("R2 R5 sat bit %0d", k),
             {line_valid, ser_out, pix_out}, {1'b1, e, {8{e}}});
      end
      order_little = 1'b0; bit_msb_first = 1'b1; sat_replicate = 1'b0;
      for (int k = 0; k < 32; k++) begin
         logic e;
         e = exp_bit(src[3], k, 1'b0, 1'b1);
         cyc(1'b1, 1'b0, 1'b0);
         chk({line_valid, ser_out, pix_out} == {1'b1, e, 8'h3C},
             $sformatf("R2 R5 margin-byte bit %0d", k),
             {line_valid, ser_out, pix_out}, {1'b1, e, 8'h3C});
      end

      // R8: margin bits serialized, buffer position kept
      avail = 5; margin_color = 8'hB4;
      cyc(1'b0, 1'b0, 1'b0);
      for (int j = 0; j < 8; j++) begin
         logic e;
         e = margin_color[7 - j];
         cyc(1'b1, 1'b1, 1'b0);
         chk({line_valid, ser_out, pix_out} == {1'b1, e, 8'hB4},
             $sformatf("R8 margin bit %0d", j),
             {line_valid, ser_out, pix_out}, {1'b1, e, 8'hB4});
      end
      cyc(1'b1, 1'b0, 1'b0);
      chk({line_valid, ser_out} == {1'b1, exp_bit(src[4], 0, 1'b0, 1'b1)},
          "R8 buffer resumes at bit 0", {line_valid, ser_out},
          {1'b1, exp_bit(src[4], 0, 1'b0, 1'b1)});

      // R11 with R1 little-endian: reset drops the partly read word
      mode_bilevel = 1'b0; order_little = 1'b1; avail = 7;
      do_reset();
      cyc(1'b1, 1'b0, 1'b0);
      chk({line_valid, pix_out} == {1'b1, 8'hEF}, "R1 little first byte",
          {line_valid, pix_out}, {1'b1, 8'hEF});
      do_reset();
      cyc(1'b1, 1'b0, 1'b0);
      chk({line_valid, pix_out} == {1'b1, 8'h67}, "R11 held word dropped",
          {line_valid, pix_out}, {1'b1, 8'h67});
      chk(ptr == 7, "R9 pop count", ptr, 7);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule